// File: doc/BRIEF.md
# Program Memory Partition Access Guard

This block sits between a processor core and a 17-bit program memory. It splits that memory into two regions with a boundary address. Any location below the boundary belongs to a protected lower region. The boundary location and everything above it belong to the upper region.

Software sets the boundary once after each reset through a small register port. The block then inspects every data-style request: table reads, writes and erases. It decides whether the request may go on to the array by comparing two addresses with the boundary. One is the address of the instruction that makes the request. The other is the target address.

Code located in the lower region may touch any location. Code located in the upper region may not touch lower-region locations with data accesses. It may still fetch and call into them. When a request is refused, the block completes the handshake itself and never raises the array enable. A refused read returns a fixed fill pattern, so the protected contents cannot leak.

The request path is a valid/ready channel passed through without registers, so the decision is made in the same cycle as the request. For a granted request, back-pressure comes from the array: `req_ready` follows `mem_ready`. The requester must hold its request fields stable while `req_valid` is high and `req_ready` is low. A refused request never stalls: `req_ready` is high in the same cycle.

Top module: `pmguard_top`

## Requirements
- R1: After reset, `lim_set` is 0 and the limit is 0. The boundary is then address 0, so every access from any instruction address is granted.
- R2: The first cycle after reset with `lim_we`=1 loads `lim_wdata` into the limit. `lim_set` reads 1 from the next cycle on.
- R3: While `lim_set` is 1, writes to the limit have no effect until the next reset. This is visible through the grant decisions at the boundary.
- R4: The boundary address is the limit value in bits 16..9, with bits 8..0 zero. An address equal to the boundary is in the upper region. The address one below it is in the lower region.
- R5: When `req_pc` is below the boundary, reads, writes and erases to any address are granted.
- R6: When `req_pc` is at or above the boundary and `req_addr` is below it, a read (`req_kind`=01), write (10) or erase (11) with `req_valid`=1 gives `deny`=1 and `mem_valid`=0 in the same cycle.
- R7: A fetch (`req_kind`=00) is never denied, whatever the addresses.
- R8: A denied read drives `rdata`=0xFF. In every other case `rdata` equals `mem_rdata`.
- R9: A granted request gives `mem_valid`=`req_valid` and `req_ready`=`mem_ready`. A denied request gives `req_ready`=1. `mem_addr` and `mem_kind` always copy `req_addr` and `req_kind`.
- R10: When both `req_pc` and `req_addr` are at or above the boundary, the access is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 8 | Limit value, boundary bits 16..9 |
| lim_set | output | 1 | Limit has been written since reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 erase |
| req_pc | input | 17 | Address of the requesting instruction |
| req_addr | input | 17 | Target address |
| deny | output | 1 | Request refused by the guard |
| mem_valid | output | 1 | Enable toward the array |
| mem_ready | input | 1 | Array accepts the request |
| mem_addr | output | 17 | Target address toward the array |
| mem_kind | output | 2 | Access kind toward the array |
| mem_rdata | input | 8 | Read data from the array |
| rdata | output | 8 | Read data to the requester |

## Verification
The limit register is the only state, so a limit write shows up one clock edge later. The bench applies a write just after an edge and judges the new boundary only in the following cycle. Every access result — `deny`, `mem_valid`, `req_ready`, `rdata` — depends only on the current inputs and the present limit, so it is due in the same cycle. The bench drives inputs just after a rising edge and compares them with its reference model at the falling edge. The model's copy of the limit advances only at the rising edge, from the values that were held during the cycle.

// File: rtl/pmguard_pkg.sv
package pmguard_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_ERASE = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/pmg_limit_reg.sv
// Write-once boundary register: first strobe after reset wins.
module pmg_limit_reg #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LIM_W-1:0] wdata,
  output logic [LIM_W-1:0] limit_q,
  output logic             locked_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q  <= '0;
      locked_q <= 1'b0;
    end else if (we && !locked_q) begin
      limit_q  <= wdata;
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pmg_region_cmp.sv
// Reports whether an address lies strictly below the boundary {limit, zeros}.
module pmg_region_cmp #(
  parameter int ADDR_W = 17,
  parameter int LIM_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LIM_W-1:0]  limit,
  output logic              below
);
  localparam int LOW_W = ADDR_W - LIM_W;
  logic [LIM_W-1:0] page;
  logic [LOW_W-1:0] offs;

  // Low bits of the boundary are zero, so only the top field decides.
  assign {page, offs} = addr;
  assign below = (page < limit);
endmodule

// File: rtl/pmg_access_gate.sv
// Grant/deny decision plus the valid/ready and read-data steering.
module pmg_access_gate #(
  parameter int            DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              pc_below,
  input  logic              addr_below,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              deny,
  output logic              mem_valid,
  output logic              req_ready,
  output logic [DATA_W-1:0] rdata
);
  import pmguard_pkg::*;
  acc_kind_e kind;
  logic      data_style;

  assign kind       = acc_kind_e'(req_kind);
  assign data_style = (kind != ACC_FETCH);

  always_comb begin
    deny      = req_valid && data_style && !pc_below && addr_below;
    mem_valid = req_valid && !deny;
    req_ready = deny ? 1'b1 : mem_ready;
    rdata     = (deny && kind == ACC_READ) ? FILL : mem_rdata;
  end
endmodule

// File: rtl/pmguard_top.sv
module pmguard_top #(
  parameter int ADDR_W = 17,
  parameter int LIM_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_we,
  input  logic [LIM_W-1:0]  lim_wdata,
  output logic              lim_set,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              deny,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_kind,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [LIM_W-1:0] limit_q;
  logic             pc_below, addr_below;

  pmg_limit_reg #(.LIM_W(LIM_W)) u_lim (
    .clk(clk), .rst_n(rst_n), .we(lim_we), .wdata(lim_wdata),
    .limit_q(limit_q), .locked_q(lim_set)
  );

  pmg_region_cmp #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_pc_cmp (
    .addr(req_pc), .limit(limit_q), .below(pc_below)
  );

  pmg_region_cmp #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_addr_cmp (
    .addr(req_addr), .limit(limit_q), .below(addr_below)
  );

  pmg_access_gate #(.DATA_W(DATA_W), .FILL({DATA_W{1'b1}})) u_gate (
    .req_valid(req_valid), .req_kind(req_kind),
    .pc_below(pc_below), .addr_below(addr_below),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .deny(deny), .mem_valid(mem_valid), .req_ready(req_ready), .rdata(rdata)
  );

  assign mem_addr = req_addr;
  assign mem_kind = req_kind;
endmodule

// File: rtl/pmguard_chk.sv
module pmguard_chk #(
  parameter int LIM_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lim_we,
  input logic [LIM_W-1:0]  lim_wdata,
  input logic [LIM_W-1:0]  limit_q,
  input logic              lim_set,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              deny,
  input logic              mem_valid,
  input logic [DATA_W-1:0] rdata
);
  a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_set && lim_we) |=> (lim_set && limit_q == $past(lim_wdata)));

  a_r3_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    lim_set |=> (lim_set && $stable(limit_q)));

  a_r7_fetch_free: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00) |-> !deny);

  a_r8_fill_read: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && req_kind == 2'b01) |-> rdata == {DATA_W{1'b1}});

  a_r6_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> (!mem_valid && req_valid));

  a_r9_deny_ready: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> req_ready);
endmodule

bind pmguard_top pmguard_chk #(.LIM_W(LIM_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_wdata(lim_wdata),
  .limit_q(limit_q), .lim_set(lim_set), .req_valid(req_valid),
  .req_ready(req_ready), .req_kind(req_kind), .deny(deny),
  .mem_valid(mem_valid), .rdata(rdata)
);

// File: tb/sim_pmguard_top.sv
`timescale 1ns/1ps
module sim_pmguard_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lim_we = 1'b0;
  logic [7:0]  lim_wdata = '0;
  logic        lim_set;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [16:0] req_pc = '0;
  logic [16:0] req_addr = '0;
  logic        deny, mem_valid;
  logic        mem_ready = 1'b0;
  logic [16:0] mem_addr;
  logic [1:0]  mem_kind;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  int ref_limit = 0;
  bit ref_set = 0;

  always #4 clk = ~clk;

  pmguard_top u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply inputs, compare at falling edge against model, advance model at rising edge.
  task automatic step(input bit v, input int k, input int pc, input int ad,
                      input bit rdy, input int md, input bit we, input int wd);
    int  bnd;
    bit  pc_lo, ad_lo, exp_deny;
    string dtag;
    req_valid = v; req_kind = k[1:0]; req_pc = pc[16:0]; req_addr = ad[16:0];
    mem_ready = rdy; mem_rdata = md[7:0]; lim_we = we; lim_wdata = wd[7:0];
    @(negedge clk);
    bnd   = ref_limit * 512;
    pc_lo = pc < bnd;
    ad_lo = ad < bnd;
    exp_deny = v && (k != 0) && !pc_lo && ad_lo;
    if (k == 0) dtag = "R7 fetch";
    else if (pc_lo) dtag = "R5 lower code";
    else if (ad_lo) dtag = "R6 upper to lower";
    else dtag = "R10 upper to upper";
    chk(dtag, deny, exp_deny);
    chk("R6/R9 mem_valid", mem_valid, v && !exp_deny);
    chk("R9 req_ready", req_ready, exp_deny ? 1 : rdy);
    chk("R9 mem_addr", mem_addr, ad);
    chk("R9 mem_kind", mem_kind, k);
    chk("R8 rdata", rdata, (exp_deny && k == 1) ? 8'hFF : md);
    chk("R2 lim_set", lim_set, ref_set);
    @(posedge clk);
    if (we && !ref_set) begin ref_limit = wd & 8'hFF; ref_set = 1; end
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lim_we = 1'b0; req_valid = 1'b0;
    ref_limit = 0; ref_set = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state, everything readable from the top of memory
    #1 chk("R1 lim_set after reset", lim_set, 0);
    step(1, 1, 17'h1FFFF, 0, 1, 8'h5A, 0, 0);
    chk("R1 read of address 0 granted", deny, 0);
    // R2: first write sets boundary 0x2000
    step(0, 0, 0, 0, 1, 0, 1, 8'h10);
    chk("R2 lim_set after write", lim_set, 1);
    // R3: second write ignored (would move boundary to 0x8000)
    step(0, 0, 0, 0, 1, 0, 1, 8'h40);
    step(1, 1, 17'h2000, 17'h2000, 1, 8'h33, 0, 0);
    chk("R3 boundary unchanged, 0x2000 still upper", deny, 0);
    // R4: exact boundary vs one below
    step(1, 1, 17'h2000, 17'h1FFF, 1, 8'h77, 0, 0);
    chk("R4 target 0x1FFF lower, denied", deny, 1);
    chk("R8 denied read fill", rdata, 8'hFF);
    step(1, 2, 17'h1FFF, 17'h0000, 0, 0, 0, 0);
    chk("R5 pc 0x1FFF lower may write", deny, 0);
    chk("R9 granted waits on mem_ready", req_ready, 0);
    step(1, 3, 17'h3000, 17'h0400, 0, 0, 0, 0);
    chk("R6 erase denied", mem_valid, 0);
    chk("R9 denied ready without mem_ready", req_ready, 1);
    step(1, 0, 17'h3000, 17'h0000, 1, 0, 0, 0);
    chk("R7 fetch into lower", deny, 0);
    step(1, 2, 17'h1E000, 17'h1FFFF, 1, 0, 0, 0);
    chk("R10 upper to upper write", mem_valid, 1);
    // Random traffic near the boundary
    for (int i = 0; i < 3000; i++) begin
      int b, pc, ad;
      b  = ref_limit * 512;
      pc = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 17'h1FFFF)
                                       : (b + $urandom_range(0, 4) - 2) & 17'h1FFFF;
      ad = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 17'h1FFFF)
                                       : (b + $urandom_range(0, 4) - 2) & 17'h1FFFF;
      step($urandom_range(0, 1), $urandom_range(0, 3), pc, ad,
           $urandom_range(0, 1), $urandom_range(0, 255),
           ($urandom_range(0, 15) == 0), $urandom_range(0, 255));
      if (i % 700 == 699) begin
        do_reset();
        #1 chk("R1 lim_set cleared by reset", lim_set, 0);
      end
    end
    // R3 window ends at reset: new value accepted
    do_reset();
    step(0, 0, 0, 0, 1, 0, 1, 8'h01);
    step(1, 1, 17'h0200, 17'h01FF, 1, 8'h12, 0, 0);
    chk("R3 new value taken after reset", deny, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule